// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This combinational unit sits beside the datapath of a double-precision fused multiply-add that computes `z + (x * y)`. It sorts each of the three binary64 operands into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. From those classes it decides whether the result is fixed by a special case. When it is, the unit supplies the final 64-bit result and the invalid-operation flag, so the arithmetic pipeline can skip its own work for that operation.

Two controls change the effective signs. `neg_product` inverts the sign of the product, which is otherwise sign(x) XOR sign(y). `neg_addend` inverts the effective sign of z. The rounding mode matters in one case only: an exact cancellation of two zeros.

The unit has no clock and no state. Its outputs follow its inputs within the same cycle.

Top module: `fma_special_resolve`

## Requirements
- R1: When x and y are both finite and nonzero (subnormal or normal) and z is zero, subnormal or normal, `special` is 0. In that case `result` is 0 and `invalid` is 0.
- R2: Signalling NaNs win over every other input. The first signalling NaN in the order z, x, y is returned with fraction bit 51 set, and `invalid` is 1.
- R3: When no signalling NaN is present, the first quiet NaN (fraction bit 51 = 1) in the order z, x, y is returned bit for bit, with `invalid` 0.
- R4: An infinity times a zero, in either order and whatever z is (NaN excepted), gives the default NaN 0x7FF8000000000000 with `invalid` 1.
- R5: An infinite product with an infinite z whose effective sign differs from the product sign gives the default NaN with `invalid` 1.
- R6: Any other infinite product gives an infinity whose sign is the product sign, after `neg_product` is applied.
- R7: A finite product (zero included) with an infinite z gives an infinity whose sign is z's sign after `neg_addend` is applied.
- R8: A zero product with a zero z of equal effective sign returns the z input bits unchanged.
- R9: A zero product with a zero z of opposite effective sign gives +0. The exception is `round_mode` = 2'b11 (toward minus infinity), which gives -0. The other codes are 00 nearest-even, 01 toward zero and 10 toward plus infinity.
- R10: A zero product with a nonzero finite z returns the z input bits unchanged, including when `neg_addend` is set.
- R11: `invalid` is 1 only in the cases of R2, R4 and R5. In every case covered by R2 to R10, `special` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| z_op | input | 64 | Addend operand, binary64 |
| x_op | input | 64 | First multiplicand, binary64 |
| y_op | input | 64 | Second multiplicand, binary64 |
| neg_product | input | 1 | Invert the product sign |
| neg_addend | input | 1 | Invert the addend's effective sign |
| round_mode | input | 2 | Rounding mode code (see R9) |
| special | output | 1 | A special case fixes the result |
| result | output | 64 | Result for the special case; 0 otherwise |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The assertions are immediate checks evaluated whenever the logic settles, so they assume every input bit is a known 0 or 1. An unknown operand would make a classification undefined. The bench therefore drives complete, defined operand words and holds them steady from one rising edge to the next, reading the outputs only at the falling edge in between. The operand set covers every class, both signs and every rounding code, so each rule is reached with its neighbouring cases.

// File: rtl/fma_sc_pkg.sv
package fma_sc_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fp_class_e;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_TOZERO  = 2'd1,
    RM_UP      = 2'd2,
    RM_DOWN    = 2'd3
  } rmode_e;
endpackage

// File: rtl/fma_op_classify.sv
module fma_op_classify
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output fp_class_e             cls,
  output logic                  sign
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign sign   = op[W-1];
  assign exp_f  = op[W-2 -: EXP_W];
  assign frac_f = op[FRAC_W-1:0];

  always_comb begin
    if (&exp_f) begin
      if (frac_f == '0)            cls = CLS_INF;
      else if (frac_f[FRAC_W-1])   cls = CLS_QNAN;
      else                         cls = CLS_SNAN;
    end else if (exp_f == '0) begin
      cls = (frac_f == '0) ? CLS_ZERO : CLS_SUB;
    end else begin
      cls = CLS_NORM;
    end
  end
endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int N_OPS  = 3
) (
  input  logic [N_OPS-1:0][EXP_W+FRAC_W:0] ops,
  input  fp_class_e                        cls [N_OPS],
  output logic                             hit,
  output logic [EXP_W+FRAC_W:0]            result,
  output logic                             invalid
);
  localparam int W = EXP_W + FRAC_W + 1;

  // Index 0 has the highest priority. Walk from lowest to highest.
  always_comb begin
    hit     = 1'b0;
    invalid = 1'b0;
    result  = '0;
    for (int i = N_OPS - 1; i >= 0; i--) begin
      if (cls[i] == CLS_QNAN) begin
        hit    = 1'b1;
        result = ops[i];
      end
    end
    for (int i = N_OPS - 1; i >= 0; i--) begin
      if (cls[i] == CLS_SNAN) begin
        hit     = 1'b1;
        invalid = 1'b1;
        result  = ops[i] | (W'(1) << (FRAC_W - 1));
      end
    end
  end

  // Every NaN that leaves here is a quiet NaN.
  always_comb begin
    if (hit) begin
      a_r2_nan_out_quiet: assert ((&result[W-2 -: EXP_W]) && result[FRAC_W-1])
        else $error("NaN output is not quiet");
    end
  end
endmodule

// File: rtl/fma_inf_zero_rules.sv
module fma_inf_zero_rules
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  fp_class_e             x_cls,
  input  fp_class_e             y_cls,
  input  fp_class_e             z_cls,
  input  logic                  prod_sign,
  input  logic                  add_sign,
  input  logic [EXP_W+FRAC_W:0] z_raw,
  input  logic [1:0]            round_mode,
  output logic                  hit,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  invalid
);
  localparam int W = EXP_W + FRAC_W + 1;
  localparam logic [W-1:0] DEF_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic x_zero, y_zero, x_inf, y_inf, z_inf, z_zero;
  logic prod_bad, prod_inf, prod_zero;

  assign x_zero = (x_cls == CLS_ZERO);
  assign y_zero = (y_cls == CLS_ZERO);
  assign x_inf  = (x_cls == CLS_INF);
  assign y_inf  = (y_cls == CLS_INF);
  assign z_inf  = (z_cls == CLS_INF);
  assign z_zero = (z_cls == CLS_ZERO);

  assign prod_bad  = (x_inf & y_zero) | (x_zero & y_inf);
  assign prod_inf  = (x_inf | y_inf) & ~prod_bad;
  assign prod_zero = (x_zero | y_zero) & ~prod_bad;

  function automatic logic [W-1:0] inf_of(input logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  always_comb begin
    hit     = 1'b0;
    invalid = 1'b0;
    result  = '0;
    if (prod_bad) begin
      hit     = 1'b1;
      invalid = 1'b1;
      result  = DEF_NAN;
    end else if (prod_inf) begin
      hit = 1'b1;
      if (z_inf && (add_sign != prod_sign)) begin
        invalid = 1'b1;
        result  = DEF_NAN;
      end else begin
        result = inf_of(prod_sign);
      end
    end else if (z_inf) begin
      hit    = 1'b1;
      result = inf_of(add_sign);
    end else if (prod_zero) begin
      hit = 1'b1;
      if (z_zero && (add_sign != prod_sign))
        result = {(round_mode == RM_DOWN), {(W-1){1'b0}}};
      else
        result = z_raw;
    end
  end

  logic any_nan;
  assign any_nan = (x_cls == CLS_QNAN) | (x_cls == CLS_SNAN) |
                   (y_cls == CLS_QNAN) | (y_cls == CLS_SNAN) |
                   (z_cls == CLS_QNAN) | (z_cls == CLS_SNAN);

  always_comb begin
    if (!any_nan && (x_inf || y_inf) && !invalid) begin
      a_r6_inf_product_sign: assert (hit && result == {prod_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}})
        else $error("infinite product lost its sign");
    end
    if (invalid) begin
      a_r5_invalid_default_nan: assert (result == DEF_NAN)
        else $error("invalid without default NaN");
    end
    if (!any_nan && prod_zero && !z_inf && !z_zero) begin
      a_r10_zero_product_keeps_z: assert (hit && result == z_raw)
        else $error("zero product altered z");
    end
  end
endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] z_op,
  input  logic [EXP_W+FRAC_W:0] x_op,
  input  logic [EXP_W+FRAC_W:0] y_op,
  input  logic                  neg_product,
  input  logic                  neg_addend,
  input  logic [1:0]            round_mode,
  output logic                  special,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  invalid
);
  localparam int W     = EXP_W + FRAC_W + 1;
  localparam int N_OPS = 3;
  localparam int IZ = 0, IX = 1, IY = 2;

  logic [N_OPS-1:0][W-1:0] ops;
  fp_class_e               cls [N_OPS];
  logic [N_OPS-1:0]        sgn;

  assign ops[IZ] = z_op;
  assign ops[IX] = x_op;
  assign ops[IY] = y_op;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fma_op_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op   (ops[g]),
      .cls  (cls[g]),
      .sign (sgn[g])
    );
  end

  logic prod_sign, add_sign;
  assign prod_sign = sgn[IX] ^ sgn[IY] ^ neg_product;
  assign add_sign  = sgn[IZ] ^ neg_addend;

  logic         nan_hit, nan_inv;
  logic [W-1:0] nan_res;
  fma_nan_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .N_OPS(N_OPS)) u_nan (
    .ops     (ops),
    .cls     (cls),
    .hit     (nan_hit),
    .result  (nan_res),
    .invalid (nan_inv)
  );

  logic         rule_hit, rule_inv;
  logic [W-1:0] rule_res;
  fma_inf_zero_rules #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rules (
    .x_cls      (cls[IX]),
    .y_cls      (cls[IY]),
    .z_cls      (cls[IZ]),
    .prod_sign  (prod_sign),
    .add_sign   (add_sign),
    .z_raw      (z_op),
    .round_mode (round_mode),
    .hit        (rule_hit),
    .result     (rule_res),
    .invalid    (rule_inv)
  );

  always_comb begin
    special = nan_hit | rule_hit;
    if (nan_hit) begin
      result  = nan_res;
      invalid = nan_inv;
    end else if (rule_hit) begin
      result  = rule_res;
      invalid = rule_inv;
    end else begin
      result  = '0;
      invalid = 1'b0;
    end
  end

  always_comb begin
    a_r11_invalid_needs_special: assert (!invalid || special)
      else $error("invalid raised outside a special case");
    if (!special) begin
      a_r1_idle_outputs_zero: assert (result == '0 && !invalid)
        else $error("idle outputs not zero");
    end
  end
endmodule

// File: tb/fma_special_resolve_tb.sv
module fma_special_resolve_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [63:0] P0   = 64'h0000000000000000;
  localparam logic [63:0] N0   = 64'h8000000000000000;
  localparam logic [63:0] ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] TWO  = 64'h4000000000000000;
  localparam logic [63:0] SUB  = 64'h0000000000000001;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] DNAN = 64'h7FF8000000000000;
  localparam logic [63:0] QZ   = 64'h7FF8000000000ABC;
  localparam logic [63:0] QX   = 64'h7FF8000000000055;
  localparam logic [63:0] QY   = 64'hFFF8000000000066;
  localparam logic [63:0] SX   = 64'h7FF0000000000123;
  localparam logic [63:0] SZ   = 64'hFFF0000000000007;
  localparam logic [63:0] SY   = 64'h7FF0000000000009;

  typedef struct packed {
    logic [63:0] z, x, y;
    logic        np, na;
    logic [1:0]  rm;
    logic        act;
    logic [63:0] res;
    logic        inv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{ONE,  TWO,  ONE,  1'b0, 1'b0, 2'd0, 1'b0, P0,   1'b0, 4'd1},  // R1
    '{P0,   SUB,  ONE,  1'b0, 1'b0, 2'd0, 1'b0, P0,   1'b0, 4'd1},  // R1 zero z
    '{QZ,   SX,   ONE,  1'b0, 1'b0, 2'd0, 1'b1, 64'h7FF8000000000123, 1'b1, 4'd2}, // R2
    '{SZ,   SX,   PINF, 1'b0, 1'b0, 2'd0, 1'b1, 64'hFFF8000000000007, 1'b1, 4'd2}, // R2
    '{ONE,  QX,   QY,   1'b0, 1'b0, 2'd0, 1'b1, QX,   1'b0, 4'd3},  // R3
    '{ONE,  ONE,  QY,   1'b0, 1'b0, 2'd0, 1'b1, QY,   1'b0, 4'd3},  // R3
    '{ONE,  PINF, P0,   1'b0, 1'b0, 2'd0, 1'b1, DNAN, 1'b1, 4'd4},  // R4
    '{NINF, N0,   PINF, 1'b0, 1'b0, 2'd0, 1'b1, DNAN, 1'b1, 4'd4},  // R4
    '{NINF, PINF, ONE,  1'b0, 1'b0, 2'd0, 1'b1, DNAN, 1'b1, 4'd5},  // R5
    '{PINF, PINF, TWO,  1'b1, 1'b0, 2'd0, 1'b1, DNAN, 1'b1, 4'd5},  // R5
    '{PINF, NINF, NINF, 1'b0, 1'b0, 2'd0, 1'b1, PINF, 1'b0, 4'd6},  // R6
    '{ONE,  PINF, TWO,  1'b1, 1'b0, 2'd0, 1'b1, NINF, 1'b0, 4'd6},  // R6
    '{NINF, PINF, ONE,  1'b1, 1'b0, 2'd0, 1'b1, NINF, 1'b0, 4'd6},  // R6
    '{PINF, ONE,  TWO,  1'b0, 1'b1, 2'd0, 1'b1, NINF, 1'b0, 4'd7},  // R7
    '{NINF, P0,   ONE,  1'b0, 1'b0, 2'd0, 1'b1, NINF, 1'b0, 4'd7},  // R7
    '{N0,   N0,   ONE,  1'b0, 1'b0, 2'd0, 1'b1, N0,   1'b0, 4'd8},  // R8
    '{P0,   P0,   P0,   1'b1, 1'b1, 2'd0, 1'b1, P0,   1'b0, 4'd8},  // R8 raw z
    '{P0,   N0,   ONE,  1'b0, 1'b0, 2'd0, 1'b1, P0,   1'b0, 4'd9},  // R9
    '{P0,   N0,   ONE,  1'b0, 1'b0, 2'd3, 1'b1, N0,   1'b0, 4'd9},  // R9 down
    '{N0,   P0,   ONE,  1'b0, 1'b0, 2'd2, 1'b1, P0,   1'b0, 4'd9},  // R9 up
    '{TWO,  P0,   SUB,  1'b0, 1'b0, 2'd0, 1'b1, TWO,  1'b0, 4'd10}, // R10
    '{SUB,  N0,   ONE,  1'b0, 1'b1, 2'd0, 1'b1, SUB,  1'b0, 4'd10}  // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] z_op = '0, x_op = '0, y_op = '0;
  logic        neg_product = 1'b0, neg_addend = 1'b0;
  logic [1:0]  round_mode = 2'd0;
  logic        special, invalid;
  logic [63:0] result;
  int          n_checks = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fma_special_resolve u_dut (
    .z_op (z_op), .x_op (x_op), .y_op (y_op),
    .neg_product (neg_product), .neg_addend (neg_addend),
    .round_mode (round_mode),
    .special (special), .result (result), .invalid (invalid)
  );

  task automatic apply_check(input vec_t v);
    @(posedge clk);
    z_op = v.z; x_op = v.x; y_op = v.y;
    neg_product = v.np; neg_addend = v.na; round_mode = v.rm;
    @(negedge clk);
    n_checks++;
    if (special !== v.act || result !== v.res || invalid !== v.inv) begin
      n_fail++;
      $display("FAIL R%0d: got special=%b result=%h invalid=%b, expected special=%b result=%h invalid=%b",
               v.req, special, result, invalid, v.act, v.res, v.inv);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: all-zero inputs are a zero product with a matching zero z (R8).
    @(negedge clk);
    n_checks++;
    if (special !== 1'b1 || result !== P0 || invalid !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 reset: got %b/%h/%b expected 1/%h/0", special, result, invalid, P0);
    end
    for (int i = 0; i < NV; i++) apply_check(VECS[i]);
    // R2: a signalling NaN in y beats a quiet NaN in z.
    apply_check('{QZ, ONE, SY, 1'b0, 1'b0, 2'd0, 1'b1, 64'h7FF8000000000009, 1'b1, 4'd2});
    // R3: a quiet NaN in z is returned even when x is infinite and y is zero.
    apply_check('{QZ, PINF, P0, 1'b0, 1'b0, 2'd0, 1'b1, QZ, 1'b0, 4'd3});
    // R11: finite operands with negations and rounding code 3 stay idle.
    apply_check('{N0, SUB, SUB, 1'b1, 1'b1, 2'd3, 1'b0, P0, 1'b0, 4'd11});
    // R7: a subnormal times an infinity in z goes to the addend sign.
    apply_check('{PINF, SUB, ONE, 1'b1, 1'b0, 2'd1, 1'b1, PINF, 1'b0, 4'd7});
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule